// File: doc/BRIEF.md
# Retractile Cascade Phase Sequencer

This block produces the ordered digital control events for a chain of retractile logic stages. Each stage has two enables. One applies the stage's input data. The other starts the ramp of the stage's supply. A start pulse launches a build-up pass, which runs from the first stage to the last. Each stage first gets its data and then its supply ramp. A step tick stands in for the duration of one ramp, so every control event waits for a tick.

When the last stage's supply ramp has completed, the sequencer holds every enable steady. It stays there until a hold-release request arrives. It then tears the cascade down in the mirror order of the build-up. Within each stage the supply ramps down first and the data is removed afterwards. A one-clock done pulse marks the removal of the first stage's data. A full compute cycle therefore takes two passes, which halves the throughput compared with a pipeline that does not retract.

Top module: `cascade_seq`

## Requirements
- R1: While rst_ni is low, every data_en_o and supply_en_o bit is 0, busy_o is 0 and done_o is 0.
- R2: A start_i pulse seen while busy_o is low starts a build-up pass. busy_o is 1 from the next cycle until the cycle in which done_o is high, and no enable changes before the first tick.
- R3: During build-up, each tick_i changes exactly one enable at the next clock edge, in this order: data_en_o[0], supply_en_o[0], data_en_o[1], supply_en_o[1], and so on up to supply_en_o[N_STAGES-1].
- R4: One further tick after supply_en_o[N_STAGES-1] rises marks the end of that ramp, and the sequencer then holds. In hold, ticks change nothing until release_i is seen high.
- R5: release_i is ignored outside hold. It changes no enable and does not raise busy_o.
- R6: During teardown, each tick_i clears exactly one enable, in this order: supply_en_o[N_STAGES-1], data_en_o[N_STAGES-1], and so on down to supply_en_o[0], then data_en_o[0].
- R7: In every cycle, supply_en_o[k] high implies data_en_o[k] high, and data_en_o[k] only falls when supply_en_o[k] was already low.
- R8: No two enable bits change at the same clock edge.
- R9: done_o is high for exactly one cycle. That cycle is the one in which data_en_o[0] first reads 0 after teardown, and busy_o is 0 in it.
- R10: A start_i pulse while busy_o is high is ignored. The pass in progress continues unchanged and no second pass follows.
- R11: While busy, a cycle without tick_i changes no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a build-up pass (only honoured when idle) |
| release_i | input | 1 | End the hold and begin teardown |
| tick_i | input | 1 | One ramp duration has elapsed |
| data_en_o | output | N_STAGES | Per-stage data-apply enable |
| supply_en_o | output | N_STAGES | Per-stage supply-ramp enable |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse after the first stage's data is removed |

## Verification
The bench builds the sequencer with N_STAGES = 3. That gives three stages and six events per direction, so a first, a middle and a last stage are all reached. The stage index needs more than one bit, so its decode is exercised fully. Two tick patterns are applied: sparse ticks with idle gaps, and ticks held high continuously. The continuous pattern brings back-to-back events and a release that arrives while a tick is also present within reach. Stray start and release pulses are injected in idle, build-up and hold.

// File: rtl/cascade_seq_pkg.sv
package cascade_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUILD,
    ST_HOLD,
    ST_RETRACT
  } seq_state_e;

  // one control event: which enable of the addressed stage, and its new level
  typedef struct packed {
    logic fire;
    logic supply;
    logic level;
  } step_ev_t;

endpackage

// File: rtl/cascade_seq_ctrl.sv
module cascade_seq_ctrl
  import cascade_seq_pkg::*;
#(
  parameter int N_STAGES = 4,
  localparam int EV_CNT = 2 * N_STAGES,
  localparam int IDX_W  = $clog2(EV_CNT + 1),
  localparam int SEL_W  = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             release_i,
  input  logic             tick_i,
  output step_ev_t         ev_o,
  output logic [SEL_W-1:0] ev_stage_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(EV_CNT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(EV_CNT - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] ev_num;
  logic             done_d, done_q;

  // teardown walks the build order backwards
  always_comb begin
    ev_num = (state_q == ST_RETRACT) ? (LAST_IDX - idx_q) : idx_q;
  end

  always_comb begin
    ev_o.fire   = tick_i && ((state_q == ST_BUILD && idx_q < FULL_IDX) ||
                             state_q == ST_RETRACT);
    ev_o.supply = ev_num[0];
    ev_o.level  = (state_q == ST_BUILD);
    ev_stage_o  = SEL_W'(ev_num >> 1);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_BUILD;
          idx_d   = '0;
        end
      end
      ST_BUILD: begin
        if (tick_i) begin
          if (idx_q == FULL_IDX) begin
            state_d = ST_HOLD;   // last supply ramp has completed
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (release_i) begin
          state_d = ST_RETRACT;
          idx_d   = '0;
        end
      end
      ST_RETRACT: begin
        if (tick_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
            idx_d   = '0;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R2
  AST_HOLD_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !release_i) |=> (state_q == ST_HOLD)); // R4
  AST_RELEASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && release_i) |=> !busy_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUILD && start_i && !tick_i) |=> $stable(idx_q)); // R10
  AST_NO_TICK_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RETRACT && !tick_i) |=> (state_q == ST_RETRACT && $stable(idx_q))); // R11

endmodule

// File: rtl/cascade_seq_stage.sv
module cascade_seq_stage
  import cascade_seq_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int STAGE_ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_ev_t         ev_i,
  input  logic [SEL_W-1:0] ev_stage_i,
  output logic             data_en_o,
  output logic             supply_en_o
);

  logic hit;
  logic data_q, supply_q;

  assign hit = ev_i.fire && (ev_stage_i == SEL_W'(STAGE_ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= 1'b0;
      supply_q <= 1'b0;
    end else if (hit) begin
      if (ev_i.supply) supply_q <= ev_i.level;
      else             data_q   <= ev_i.level;
    end
  end

  assign data_en_o   = data_q;
  assign supply_en_o = supply_q;

  AST_SUPPLY_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_q |-> data_q); // R7
  AST_DATA_AFTER_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_q) |-> !$past(supply_q)); // R7

endmodule

// File: rtl/cascade_seq.sv
module cascade_seq
  import cascade_seq_pkg::*;
#(
  parameter int N_STAGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                release_i,
  input  logic                tick_i,
  output logic [N_STAGES-1:0] data_en_o,
  output logic [N_STAGES-1:0] supply_en_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam int SEL_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;

  step_ev_t         ev;
  logic [SEL_W-1:0] ev_stage;

  cascade_seq_ctrl #(
    .N_STAGES(N_STAGES)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .release_i (release_i),
    .tick_i    (tick_i),
    .ev_o      (ev),
    .ev_stage_o(ev_stage),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    cascade_seq_stage #(
      .SEL_W   (SEL_W),
      .STAGE_ID(k)
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ev_i       (ev),
      .ev_stage_i (ev_stage),
      .data_en_o  (data_en_o[k]),
      .supply_en_o(supply_en_o[k])
    );
  end

  AST_ONE_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({supply_en_o, data_en_o} ^ $past({supply_en_o, data_en_o})) <= 1); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable({supply_en_o, data_en_o})); // R5

endmodule

// File: tb/cascade_seq_test.sv
`timescale 1ns/1ps
module cascade_seq_test;
  localparam int N = 3;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, release_i = 1'b0, tick_i = 1'b0;
  logic [N-1:0] data_en_o, supply_en_o;
  logic busy_o, done_o;

  int checks = 0, fails = 0, done_cnt = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cascade_seq #(.N_STAGES(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .release_i(release_i),
    .tick_i(tick_i), .data_en_o(data_en_o), .supply_en_o(supply_en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // code = bit index * 2 + new level; data bit k = k, supply bit k = N + k
  task automatic push_build();
    for (int k = 0; k < N; k++) begin
      exp_q.push_back(k * 2 + 1);
      exp_q.push_back((N + k) * 2 + 1);
    end
  endtask

  task automatic push_retract();
    for (int k = N - 1; k >= 0; k--) begin
      exp_q.push_back((N + k) * 2);
      exp_q.push_back(k * 2);
    end
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // monitor: scoreboard of enable transitions
  initial begin
    logic [W-1:0] prev, cur, diff;
    int bi, code, e;
    bit dexp;
    prev = '0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        cur  = {supply_en_o, data_en_o};
        diff = cur ^ prev;
        chk((supply_en_o & ~data_en_o) == '0, "R7", "supply without data",
            int'(supply_en_o), int'(supply_en_o & data_en_o));
        dexp = 1'b0;
        if (diff != '0) begin
          chk($countones(diff) == 1, "R8", "bits changed at once", $countones(diff), 1);
          bi = 0;
          for (int b = 0; b < W; b++) if (diff[b]) bi = b;
          code = bi * 2 + int'(cur[bi]);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected enable event", code, -1);
          end else begin
            e = exp_q.pop_front();
            if (e % 2 == 1) chk(code == e, "R3", "build event", code, e);
            else            chk(code == e, "R6", "teardown event", code, e);
          end
          dexp = (bi == 0 && cur[0] == 1'b0);
        end
        chk(done_o == dexp, "R9", "done pulse", int'(done_o), int'(dexp));
        if (done_o) begin
          done_cnt++;
          chk(!busy_o, "R9", "busy during done", int'(busy_o), 0);
        end
        prev = cur;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({supply_en_o, data_en_o} == '0, "R1", "enables in reset", int'({supply_en_o, data_en_o}), 0);
    chk(!busy_o, "R1", "busy in reset", int'(busy_o), 0);
    chk(!done_o, "R1", "done in reset", int'(done_o), 0);
    rst_ni = 1'b1;

    // release and ticks while idle
    @(negedge clk) release_i = 1'b1;
    tick_n(3);
    @(negedge clk) release_i = 1'b0;
    chk(!busy_o, "R5", "busy after idle release", int'(busy_o), 0);
    chk({supply_en_o, data_en_o} == '0, "R5", "enables after idle release",
        int'({supply_en_o, data_en_o}), 0);

    // pass 1: sparse ticks
    push_build();
    pulse_start();
    chk(busy_o, "R2", "busy after start", int'(busy_o), 1);
    repeat (5) @(negedge clk);
    chk({supply_en_o, data_en_o} == '0, "R2", "no event before tick",
        int'({supply_en_o, data_en_o}), 0);
    tick_n(1);
    pulse_start(); // R10: ignored mid-build
    repeat (4) @(negedge clk);
    chk(data_en_o == 3'b001 && supply_en_o == '0, "R11", "idle gap in build",
        int'({supply_en_o, data_en_o}), 1);
    tick_n(W);
    tick_n(4);
    pulse_start(); // R10: ignored in hold
    chk({supply_en_o, data_en_o} == '1, "R4", "all enables held",
        int'({supply_en_o, data_en_o}), (1 << W) - 1);
    chk(busy_o, "R4", "busy in hold", int'(busy_o), 1);
    chk(exp_q.size() == 0, "R3", "build events outstanding", exp_q.size(), 0);
    push_retract();
    @(negedge clk) release_i = 1'b1;
    @(negedge clk) release_i = 1'b0;
    tick_n(W);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "teardown events outstanding", exp_q.size(), 0);
    chk(!busy_o, "R10", "no second pass", int'(busy_o), 0);
    chk(done_cnt == 1, "R9", "done count pass 1", done_cnt, 1);

    // pass 2: tick held high every cycle
    push_build();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) begin start_i = 1'b0; tick_i = 1'b1; end
    repeat (W + 4) @(negedge clk);
    chk({supply_en_o, data_en_o} == '1, "R4", "hold under continuous ticks",
        int'({supply_en_o, data_en_o}), (1 << W) - 1);
    push_retract();
    release_i = 1'b1;
    @(negedge clk) release_i = 1'b0;
    repeat (W + 2) @(negedge clk);
    tick_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "teardown events outstanding pass 2", exp_q.size(), 0);
    chk(!busy_o, "R2", "busy cleared after pass 2", int'(busy_o), 0);
    chk(done_cnt == 2, "R9", "done count pass 2", done_cnt, 2);
    chk({supply_en_o, data_en_o} == '0, "R6", "all enables removed",
        int'({supply_en_o, data_en_o}), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule